// File: doc/BRIEF.md
# Wiper Position Register with Step Control

This block holds the volatile position of a digitally set resistor-ladder wiper and turns it into the enable pattern for the tap switches. The position is a parameterised word, 8 bits by default. It is decoded into a one-hot vector of `2**W` switch enables, so exactly one tap connects to the wiper. Tap 0 is the low-terminal end of the ladder and the all-ones code is the high-terminal end.

The position can be changed from four sources:
- a serial write value handed over by the command decoder;
- a parallel transfer from one of the default bank's stored data registers;
- single up or down steps, one per enabled clock;
- a recall of data register slot 0.

The recall runs by itself on the first clock after reset is released. A requester can also trigger it through a dedicated input. When several requests arrive in one cycle, a fixed priority picks one of them. Steps stop at the ends of the ladder instead of wrapping. The tap vector is registered and changes only in the cycle where the position changes.

Top module: `wiper_position`

## Requirements
- R1: While `rst_n` is low, `pos_o` is 0 and `tap_o` has only bit 0 set. Reset release passes through a two-flop synchroniser. `pos_o` takes the value of data slot 0 (`bank_i[W-1:0]`) on the third rising clock edge after `rst_n` rises, and reads 0 before that edge.
- R2: `tap_o` always has exactly one bit set, and that bit's index equals `pos_o`. Position 0 sets `tap_o[0]` (low end) and position `2**W-1` sets the top bit (high end).
- R3: A pulse on `recall_i` loads data slot 0 into the position on the next clock.
- R4: With `step_en_i` high and no other request, `step_up_i`=1 raises the position by one and `step_up_i`=0 lowers it by one, on the next clock.
- R5: With `wr_en_i` high and no recall pending, the position takes `wr_data_i` on the next clock.
- R6: With `xfr_en_i` high and no recall or write, the position takes data slot `xfr_sel_i` on the next clock. Slot k occupies `bank_i[k*W +: W]`.
- R7: A step up at the all-ones code and a step down at 0 leave the position unchanged.
- R8: Simultaneous requests resolve in this order: recall first, then write, then transfer, then step.
- R9: With no request, `pos_o` and `tap_o` hold their values.
- R10: `tap_o` is registered and updates in the same cycle as `pos_o`. It never shows a tap other than the current position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_i | input | 1 | Request reload from data slot 0 |
| wr_en_i | input | 1 | Direct write strobe |
| wr_data_i | input | W | Direct write value |
| xfr_en_i | input | 1 | Transfer strobe from a data slot |
| xfr_sel_i | input | $clog2(NREG) | Data slot index for transfer |
| bank_i | input | NREG*W | Stored data slots, slot k at bits k*W +: W |
| step_en_i | input | 1 | Single-step enable |
| step_up_i | input | 1 | Step direction, 1 toward high end |
| pos_o | output | W | Current wiper position |
| tap_o | output | 2**W | One-hot tap switch enables |

## Verification
The hardest situations to reach are colliding requests and the ends of the ladder. The automatic recall is hard in a second way: it happens only once, in a single cycle after reset release, so its timing and source can only be seen right then. The stimulus table drives three and four requests in the same cycle and walks the position onto the all-ones code and onto zero before stepping past each end. Directed tests assert reset with a write already pending, change slot 0 between resets, and sample the position on each edge of the synchroniser window.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_WRITE  = 3'd2,
    SRC_XFER   = 3'd3,
    SRC_STEP   = 3'd4
  } load_src_e;

endpackage

// File: rtl/wiper_rst_sync.sv
module wiper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/wiper_next.sv
module wiper_next
  import wiper_pkg::*;
#(
  parameter int W     = 8,
  parameter int NREG  = 4,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [W-1:0]      pos_q,
  input  logic              recall,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              xfr_en,
  input  logic [SELW-1:0]   xfr_sel,
  input  logic [NREG*W-1:0] bank,
  input  logic              step_en,
  input  logic              step_up,
  output load_src_e         src,
  output logic [W-1:0]      pos_d
);

  localparam logic [W-1:0] POS_MAX = {W{1'b1}};
  localparam logic [W-1:0] POS_MIN = '0;

  logic [W-1:0] slot_val;
  logic [W-1:0] step_val;

  always_comb begin
    slot_val = bank[xfr_sel*W +: W];
  end

  always_comb begin
    step_val = pos_q;
    if (step_up) begin
      if (pos_q != POS_MAX) step_val = pos_q + 1'b1;
    end else begin
      if (pos_q != POS_MIN) step_val = pos_q - 1'b1;
    end
  end

  always_comb begin
    if (recall)       src = SRC_RECALL;
    else if (wr_en)   src = SRC_WRITE;
    else if (xfr_en)  src = SRC_XFER;
    else if (step_en) src = SRC_STEP;
    else              src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: pos_d = bank[W-1:0];
      SRC_WRITE:  pos_d = wr_data;
      SRC_XFER:   pos_d = slot_val;
      SRC_STEP:   pos_d = step_val;
      default:    pos_d = pos_q;
    endcase
  end

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int W     = 8,
  localparam int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [W-1:0]    pos_d,
  output logic [TAPS-1:0] tap_q
);

  logic [TAPS-1:0] tap_d;

  for (genvar gi = 0; gi < TAPS; gi++) begin : g_tap
    localparam logic [W-1:0] IDX = gi[W-1:0];
    assign tap_d[gi] = (pos_d == IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= {{(TAPS-1){1'b0}}, 1'b1};
    end else if (upd_en) begin
      tap_q <= tap_d;
    end
  end

endmodule

// File: rtl/wiper_position.sv
module wiper_position
  import wiper_pkg::*;
#(
  parameter int W     = 8,
  parameter int NREG  = 4,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recall_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              xfr_en_i,
  input  logic [SELW-1:0]   xfr_sel_i,
  input  logic [NREG*W-1:0] bank_i,
  input  logic              step_en_i,
  input  logic              step_up_i,
  output logic [W-1:0]      pos_o,
  output logic [TAPS-1:0]   tap_o
);

  logic         rst_q;
  logic         recall_pend;
  logic         recall_all;
  logic [W-1:0] pos_q;
  logic [W-1:0] pos_d;
  logic         pos_upd;
  load_src_e    src;

  wiper_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign recall_all = recall_i | recall_pend;

  wiper_next #(.W(W), .NREG(NREG)) u_next (
    .pos_q   (pos_q),
    .recall  (recall_all),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .xfr_en  (xfr_en_i),
    .xfr_sel (xfr_sel_i),
    .bank    (bank_i),
    .step_en (step_en_i),
    .step_up (step_up_i),
    .src     (src),
    .pos_d   (pos_d)
  );

  assign pos_upd = (src != SRC_NONE) && (pos_d != pos_q);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      recall_pend <= 1'b1;
    end else begin
      recall_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pos_q <= '0;
    end else if (pos_upd) begin
      pos_q <= pos_d;
    end
  end

  wiper_tap_decode #(.W(W)) u_tap (
    .clk    (clk),
    .rst_n  (rst_q),
    .upd_en (pos_upd),
    .pos_d  (pos_d),
    .tap_q  (tap_o)
  );

  assign pos_o = pos_q;

endmodule

// File: rtl/wiper_position_chk.sv
module wiper_position_chk #(
  parameter int W     = 8,
  parameter int NREG  = 4,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TAPS = 1 << W
) (
  input logic              clk,
  input logic              rst_q,
  input logic              recall_pend,
  input logic              recall_i,
  input logic              wr_en_i,
  input logic [W-1:0]      wr_data_i,
  input logic              xfr_en_i,
  input logic [SELW-1:0]   xfr_sel_i,
  input logic [NREG*W-1:0] bank_i,
  input logic              step_en_i,
  input logic              step_up_i,
  input logic [W-1:0]      pos_o,
  input logic [TAPS-1:0]   tap_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         rec;
  logic [W-1:0] sel_val;
  logic [W-1:0] slot0;
  logic         idle;

  assign rec     = recall_i | recall_pend;
  assign sel_val = bank_i[xfr_sel_i*W +: W];
  assign slot0   = bank_i[W-1:0];
  assign idle    = !rec && !wr_en_i && !xfr_en_i && !step_en_i;

  // R2, R10
  a_r2_tap_onehot: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(tap_o) == 1);

  a_r10_tap_at_pos: assert property (@(posedge clk) disable iff (!rst_q)
    tap_o[pos_o]);

  // R3, R8
  a_r3_recall_load: assert property (@(posedge clk) disable iff (!rst_q)
    rec |=> pos_o == $past(slot0));

  // R5, R8
  a_r5_write_load: assert property (@(posedge clk) disable iff (!rst_q)
    (!rec && wr_en_i) |=> pos_o == $past(wr_data_i));

  // R6, R8
  a_r6_xfer_load: assert property (@(posedge clk) disable iff (!rst_q)
    (!rec && !wr_en_i && xfr_en_i) |=> pos_o == $past(sel_val));

  // R4
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_q)
    (!rec && !wr_en_i && !xfr_en_i && step_en_i && step_up_i && pos_o != TOP)
    |=> pos_o == $past(pos_o) + 1'b1);

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_q)
    (!rec && !wr_en_i && !xfr_en_i && step_en_i && !step_up_i && pos_o != '0)
    |=> pos_o == $past(pos_o) - 1'b1);

  // R7
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_q)
    (!rec && !wr_en_i && !xfr_en_i && step_en_i &&
     ((step_up_i && pos_o == TOP) || (!step_up_i && pos_o == '0)))
    |=> $stable(pos_o));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_q)
    idle |=> ($stable(pos_o) && $stable(tap_o)));

endmodule

bind wiper_position wiper_position_chk #(.W(W), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .recall_pend (recall_pend),
  .recall_i    (recall_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .xfr_en_i    (xfr_en_i),
  .xfr_sel_i   (xfr_sel_i),
  .bank_i      (bank_i),
  .step_en_i   (step_en_i),
  .step_up_i   (step_up_i),
  .pos_o       (pos_o),
  .tap_o       (tap_o)
);

// File: tb/wiper_position_test.sv
module wiper_position_test;

  localparam int W    = 8;
  localparam int NREG = 4;
  localparam int TAPS = 1 << W;
  localparam int NVEC = 18;

  // row: rec, wr, wdata[8], xfr, sel[2], step, up, exp[8]  (23 bits)
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 8'hAA},  // R5 write
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'hAB},  // R4 up
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'hAA},  // R4 down
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 8'h13},  // R6 slot1
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 8'hC7},  // R6 slot2
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 1'b0, 1'b0, 8'hFE},  // R6 slot3
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'hFF},  // R2 high end
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'hFF},  // R7 top sat
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'hFF},  // R9 idle
    {1'b0, 1'b1, 8'h01, 1'b0, 2'd0, 1'b0, 1'b0, 8'h01},  // R5
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00},  // R2 low end
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00},  // R7 bottom sat
    {1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00},  // R9 idle
    {1'b0, 1'b1, 8'h33, 1'b1, 2'd3, 1'b1, 1'b1, 8'h33},  // R8 write wins
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b0, 8'h13},  // R8 xfer over step
    {1'b1, 1'b1, 8'h77, 1'b1, 2'd2, 1'b1, 1'b1, 8'h5A},  // R3 R8 recall wins
    {1'b0, 1'b1, 8'h10, 1'b0, 2'd0, 1'b0, 1'b0, 8'h10},  // R5
    {1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 8'h5A}   // R6 slot0
  };

  logic              clk;
  logic              rst_n;
  logic              recall_i;
  logic              wr_en_i;
  logic [W-1:0]      wr_data_i;
  logic              xfr_en_i;
  logic [1:0]        xfr_sel_i;
  logic [NREG*W-1:0] bank_i;
  logic              step_en_i;
  logic              step_up_i;
  logic [W-1:0]      pos_o;
  logic [TAPS-1:0]   tap_o;

  int checks;
  int errors;
  int cycles;
  bit done;

  wiper_position #(.W(W), .NREG(NREG)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .recall_i  (recall_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .xfr_en_i  (xfr_en_i),
    .xfr_sel_i (xfr_sel_i),
    .bank_i    (bank_i),
    .step_en_i (step_en_i),
    .step_up_i (step_up_i),
    .pos_o     (pos_o),
    .tap_o     (tap_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk_pos(input string req, input logic [W-1:0] exp);
    checks++;
    if (pos_o !== exp) begin
      errors++;
      $display("FAIL %s: pos_o actual %02h expected %02h", req, pos_o, exp);
    end
  endtask

  task automatic chk_tap(input string req, input logic [W-1:0] exp);
    logic [TAPS-1:0] want;
    want = {{(TAPS-1){1'b0}}, 1'b1} << exp;
    checks++;
    if (tap_o !== want) begin
      errors++;
      $display("FAIL %s: tap_o ones=%0d bit[%0d]=%b, expected only bit %0d set",
               req, $countones(tap_o), exp, tap_o[exp], exp);
    end
  endtask

  task automatic idle_inputs();
    recall_i  = 1'b0;
    wr_en_i   = 1'b0;
    wr_data_i = '0;
    xfr_en_i  = 1'b0;
    xfr_sel_i = '0;
    step_en_i = 1'b0;
    step_up_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        errors++;
        $display("FAIL watchdog: cycles actual %0d expected <= 5000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    idle_inputs();
    bank_i = {8'hFE, 8'hC7, 8'h13, 8'h5A};
    rst_n  = 1'b0;
    wr_en_i   = 1'b1;     // pending write during reset must not matter
    wr_data_i = 8'hE1;
    repeat (3) @(negedge clk);
    chk_pos("R1 reset value", 8'h00);
    chk_tap("R1 reset tap", 8'h00);
    idle_inputs();

    // release and watch the synchroniser window
    rst_n = 1'b1;
    @(negedge clk);
    chk_pos("R1 sync edge 1", 8'h00);
    @(negedge clk);
    chk_pos("R1 sync edge 2", 8'h00);
    @(negedge clk);
    chk_pos("R1 recall after release", 8'h5A);
    chk_tap("R1 R10 tap after recall", 8'h5A);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      recall_i  = VEC[i][22];
      wr_en_i   = VEC[i][21];
      wr_data_i = VEC[i][20:13];
      xfr_en_i  = VEC[i][12];
      xfr_sel_i = VEC[i][11:10];
      step_en_i = VEC[i][9];
      step_up_i = VEC[i][8];
      @(negedge clk);
      chk_pos($sformatf("R2-R9 vector %0d pos", i), VEC[i][7:0]);
      chk_tap($sformatf("R2 R10 vector %0d tap", i), VEC[i][7:0]);
    end
    idle_inputs();

    // R3: recall tracks the live slot 0 contents
    bank_i[7:0] = 8'h21;
    recall_i = 1'b1;
    @(negedge clk);
    recall_i = 1'b0;
    chk_pos("R3 recall new slot0", 8'h21);
    @(negedge clk);
    chk_pos("R9 hold after recall", 8'h21);

    // R1: asynchronous reset mid-run, then recall of the new default
    wr_en_i   = 1'b1;
    wr_data_i = 8'h99;
    @(negedge clk);
    chk_pos("R5 write before reset", 8'h99);
    idle_inputs();
    #3 rst_n = 1'b0;
    #2;
    chk_pos("R1 async reset clears", 8'h00);
    chk_tap("R1 async reset tap", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_pos("R1 still zero in sync window", 8'h00);
    @(negedge clk);
    chk_pos("R1 recall of new default", 8'h21);
    chk_tap("R1 R2 tap of new default", 8'h21);

    // R4: step on the edge following the recall
    step_en_i = 1'b1;
    step_up_i = 1'b1;
    repeat (3) @(negedge clk);
    chk_pos("R4 three steps up", 8'h24);
    idle_inputs();

    finish_run();
  end

endmodule